// File: doc/BRIEF.md
# Timer with Assignable Prescaler

This block is a 16-bit up-counter that can also run as an 8-bit counter. Its increment stream comes from a qualified clock, which is either every cycle of the system clock or a chosen edge of an external count pin. An 8-bit prescaler can be placed between the qualified clock and the counter to divide by 2 up to 256 in powers of two. A single bit of the control byte bypasses the prescaler. The prescaler count is hidden, and any write to the timer bytes returns it to zero.

When the counter rolls over, a sticky overflow flag is set. The rollover point is FFh in 8-bit mode and FFFFh in 16-bit mode. The interrupt request is the flag gated by an enable bit. Software writes the control byte, the low and high timer bytes, the flag and the enable through single-cycle write strobes that share one data byte. A sleep input stops all counting.

Top module: `prescaled_timer`

## Requirements
- R1: After a synchronous active-low reset, cnt_o is 0000h, flag_o and irq_o are 0, the enable is 0 and the control byte is FFh: 8-bit mode, external source on falling edges, prescaler bypassed, running. While the external pin is idle the count does not move.
- R2: The control byte is laid out as bit 7 run, bit 6 8-bit mode, bit 5 external source (0 selects the system clock), bit 4 falling edge, bit 3 bypass, bits 2:0 ratio. With the internal source and bypass=1, the count rises by one on every clock while run=1.
- R3: With bypass=0, the counter advances once per 2^(ratio+1) qualified clocks, so ratio 000 divides by 2 and 111 by 256. The prescaler starts from zero.
- R4: A write to either timer byte clears the prescaler count in the same cycle. That write takes priority over an increment in that cycle.
- R5: In 8-bit mode only the low byte counts. A rollover from FFh to 00h sets flag_o and leaves the high byte unchanged.
- R6: In 16-bit mode, a low-byte rollover carries into the high byte without setting the flag. A rollover from FFFFh to 0000h sets flag_o.
- R7: irq_o is 1 exactly when flag_o is 1 and the enable (written from wr_data_i[0]) is 1.
- R8: flag_o stays set until a flag write with wr_data_i[0]=0 clears it. An overflow in the same cycle as that clear leaves the flag set.
- R9: With run=0 the count holds.
- R10: While sleep_i is 1 the count holds, so no overflow can occur.
- R11: The external pin passes through two synchronizer flops before edge detection. A qualifying edge shows in cnt_o three clocks after the pin changes. Edges of the other polarity are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_cnt_i | input | 1 | External count pin (asynchronous) |
| sleep_i | input | 1 | Sleep request, stops counting |
| wr_ctrl_i | input | 1 | Write control byte from wr_data_i |
| wr_tmr_lo_i | input | 1 | Write timer low byte |
| wr_tmr_hi_i | input | 1 | Write timer high byte |
| wr_flag_i | input | 1 | Write overflow flag from wr_data_i[0] |
| wr_ie_i | input | 1 | Write interrupt enable from wr_data_i[0] |
| wr_data_i | input | 8 | Shared write data |
| cnt_o | output | 16 | Current timer value {high, low} |
| flag_o | output | 1 | Overflow flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check several properties on every cycle. Without a timer write, the count either holds, steps by one, or wraps only its low byte. Sleep and a cleared run bit freeze the count. The flag stays set until it is cleared. A request never appears without the flag, and a flag that rises on its own comes from a low byte passing FFh to 00h.

Other behaviours can only be shown by the bench's scenarios: the exact division for each ratio, the prescaler clear on a timer write, the choice of edge and the three-clock pin latency, the 8-bit versus 16-bit rollover points, and the overflow beating a same-cycle clear.

// File: rtl/pt_pkg.sv
// Package: shared control-byte layout and reset value for the prescaled timer.
// Assumes: bit order of the control byte is fixed, since software encodes it.
package pt_pkg;

    localparam int BYTE_W = 8;

    typedef struct packed {
        logic       run;        // bit 7: counting allowed
        logic       width8;     // bit 6: 8-bit mode
        logic       ext_src;    // bit 5: external pin source
        logic       fall_edge;  // bit 4: count falling edges of pin
        logic       bypass;     // bit 3: prescaler out of the path
        logic [2:0] ratio;      // bits 2:0: divide by 2^(ratio+1)
    } tmr_ctrl_t;

    localparam tmr_ctrl_t CTRL_RST = 8'hFF;

endpackage

// File: rtl/pt_edge_sync.sv
// Module: synchronizes the external count pin and emits a one-cycle pulse on the
// selected edge. Assumes the pin is asynchronous; STAGES >= 2 synchronizer flops.
module pt_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic fall_sel_i,
    output logic edge_o
);

    logic [STAGES-1:0] sync_q;
    logic              prev_q;
    logic              cur;

    assign cur = sync_q[STAGES-1];

    // Shift the pin through the synchronizer and keep the last synced value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin_i};
            prev_q <= cur;
        end
    end

    // Pulse when the synced level changes in the selected direction.
    always_comb begin
        if (fall_sel_i) edge_o = prev_q & ~cur;
        else            edge_o = ~prev_q & cur;
    end

endmodule

// File: rtl/pt_prescaler.sv
// Module: hidden free-running divider. tick_o pulses on the advance that completes
// a block of 2^(ratio+1) advances. Assumes clr_i has priority over adv_i.
module pt_prescaler #(
    parameter int PRE_W   = 8,
    parameter int RATIO_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_i,
    input  logic               adv_i,
    input  logic [RATIO_W-1:0] ratio_i,
    output logic               tick_o
);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;

    // Low (ratio+1) bits set; wraps to all ones at the widest ratio.
    assign mask   = (PRE_W'(2) << ratio_i) - PRE_W'(1);
    assign tick_o = adv_i & (&(pre_q | ~mask));

    // Count advances; cleared by reset or a timer write.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) pre_q <= '0;
        else if (adv_i)      pre_q <= pre_q + PRE_W'(1);
    end

endmodule

// File: rtl/pt_count_core.sv
// Module: the 8/16-bit counter with byte writes and a one-cycle overflow pulse.
// Assumes a byte write in a cycle suppresses that cycle's increment.
module pt_count_core
    import pt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc_i,
    input  logic              width8_i,
    input  logic              wr_lo_i,
    input  logic              wr_hi_i,
    input  logic [BYTE_W-1:0] data_i,
    output logic [2*BYTE_W-1:0] cnt_o,
    output logic              ovf_o
);

    logic [BYTE_W-1:0] lo_q, hi_q;
    logic              any_wr;
    logic              step;

    assign any_wr = wr_lo_i | wr_hi_i;
    assign step   = inc_i & ~any_wr;
    assign cnt_o  = {hi_q, lo_q};

    // Overflow when the width in use is all ones on an accepted step.
    always_comb begin
        if (width8_i) ovf_o = step & (&lo_q);
        else          ovf_o = step & (&lo_q) & (&hi_q);
    end

    // Update bytes from writes, otherwise from the increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (any_wr) begin
            if (wr_lo_i) lo_q <= data_i;
            if (wr_hi_i) hi_q <= data_i;
        end else if (step) begin
            if (width8_i) lo_q <= lo_q + BYTE_W'(1);
            else          {hi_q, lo_q} <= {hi_q, lo_q} + (2*BYTE_W)'(1);
        end
    end

endmodule

// File: rtl/prescaled_timer.sv
// Module: top of the timer. Holds the control byte, enable and flag, forms the
// qualified clock and wires synchronizer, prescaler and counter together.
// Assumes the internal source advances on every system clock cycle.
module prescaled_timer
    import pt_pkg::*;
#(
    parameter int PRE_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ext_cnt_i,
    input  logic        sleep_i,
    input  logic        wr_ctrl_i,
    input  logic        wr_tmr_lo_i,
    input  logic        wr_tmr_hi_i,
    input  logic        wr_flag_i,
    input  logic        wr_ie_i,
    input  logic [7:0]  wr_data_i,
    output logic [15:0] cnt_o,
    output logic        flag_o,
    output logic        irq_o
);

    localparam int RATIO_W = 3;

    tmr_ctrl_t ctrl_q;
    logic      ie_q, flag_q;
    logic      run_en, ext_edge, qclk, pre_tick, inc, ovf;

    assign run_en = ctrl_q.run;

    // Control byte and enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RST;
            ie_q   <= 1'b0;
        end else begin
            if (wr_ctrl_i) ctrl_q <= tmr_ctrl_t'(wr_data_i);
            if (wr_ie_i)   ie_q   <= wr_data_i[0];
        end
    end

    pt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_i      (ext_cnt_i),
        .fall_sel_i (ctrl_q.fall_edge),
        .edge_o     (ext_edge)
    );

    // Qualified clock: running, awake, and the selected source active.
    assign qclk = run_en & ~sleep_i & (ctrl_q.ext_src ? ext_edge : 1'b1);

    pt_prescaler #(.PRE_W(PRE_W), .RATIO_W(RATIO_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (wr_tmr_lo_i | wr_tmr_hi_i),
        .adv_i   (qclk & ~ctrl_q.bypass),
        .ratio_i (ctrl_q.ratio),
        .tick_o  (pre_tick)
    );

    assign inc = ctrl_q.bypass ? qclk : pre_tick;

    pt_count_core u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc_i    (inc),
        .width8_i (ctrl_q.width8),
        .wr_lo_i  (wr_tmr_lo_i),
        .wr_hi_i  (wr_tmr_hi_i),
        .data_i   (wr_data_i),
        .cnt_o    (cnt_o),
        .ovf_o    (ovf)
    );

    // Sticky flag: overflow sets and beats a same-cycle software write.
    always_ff @(posedge clk) begin
        if (!rst_n)         flag_q <= 1'b0;
        else if (ovf)       flag_q <= 1'b1;
        else if (wr_flag_i) flag_q <= wr_data_i[0];
    end

    assign flag_o = flag_q;
    assign irq_o  = flag_q & ie_q;

endmodule

// File: rtl/prescaled_timer_chk.sv
// Module: cycle-by-cycle properties of the timer, bound to the top module.
// Assumes reset is held for at least one clock before release.
module prescaled_timer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        sleep_i,
    input logic        wr_tmr_lo_i,
    input logic        wr_tmr_hi_i,
    input logic        wr_flag_i,
    input logic [7:0]  wr_data_i,
    input logic        run_i,
    input logic [15:0] cnt_o,
    input logic        flag_o,
    input logic        irq_o
);

    // R2 R5 R6: without a timer write the count holds, steps by one or wraps its low byte.
    a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_tmr_lo_i && !wr_tmr_hi_i) |=>
            (cnt_o == $past(cnt_o)) || (cnt_o == $past(cnt_o) + 16'd1) ||
            (cnt_o == {$past(cnt_o[15:8]), 8'h00}));

    // R9: a stopped timer holds its value.
    a_r9_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !wr_tmr_lo_i && !wr_tmr_hi_i) |=> $stable(cnt_o));

    // R10: sleep freezes the count.
    a_r10_sleep_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_i && !wr_tmr_lo_i && !wr_tmr_hi_i) |=> $stable(cnt_o));

    // R10: no overflow while asleep.
    a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_i && !flag_o && !wr_flag_i) |=> !flag_o);

    // R8: the flag is sticky unless cleared.
    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !(wr_flag_i && !wr_data_i[0])) |=> flag_o);

    // R7: no request without the flag.
    a_r7_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> flag_o);

    // R5 R6: a flag rising without a flag write comes from a low-byte rollover.
    a_r5_rollover_source: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(flag_o) && !$past(wr_flag_i)) |->
            (cnt_o[7:0] == 8'h00) && ($past(cnt_o[7:0]) == 8'hFF));

endmodule

bind prescaled_timer prescaled_timer_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sleep_i     (sleep_i),
    .wr_tmr_lo_i (wr_tmr_lo_i),
    .wr_tmr_hi_i (wr_tmr_hi_i),
    .wr_flag_i   (wr_flag_i),
    .wr_data_i   (wr_data_i),
    .run_i       (run_en),
    .cnt_o       (cnt_o),
    .flag_o      (flag_o),
    .irq_o       (irq_o)
);

// File: tb/prescaled_timer_bench.sv
// Bench: table of internal-clock vectors walked by one loop, then directed tests
// for reset, external edges, prescaler clear, interrupt gating and sleep.
module prescaled_timer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_cnt_i = 1'b0;
    logic        sleep_i = 1'b0;
    logic        wr_ctrl_i = 1'b0, wr_tmr_lo_i = 1'b0, wr_tmr_hi_i = 1'b0;
    logic        wr_flag_i = 1'b0, wr_ie_i = 1'b0;
    logic [7:0]  wr_data_i = 8'h00;
    logic [15:0] cnt_o;
    logic        flag_o, irq_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    prescaled_timer u_prescaled_timer (
        .clk(clk), .rst_n(rst_n), .ext_cnt_i(ext_cnt_i), .sleep_i(sleep_i),
        .wr_ctrl_i(wr_ctrl_i), .wr_tmr_lo_i(wr_tmr_lo_i), .wr_tmr_hi_i(wr_tmr_hi_i),
        .wr_flag_i(wr_flag_i), .wr_ie_i(wr_ie_i), .wr_data_i(wr_data_i),
        .cnt_o(cnt_o), .flag_o(flag_o), .irq_o(irq_o)
    );

    typedef struct packed {
        logic [7:0]  ctrl;
        logic [7:0]  lo;
        logic [7:0]  hi;
        logic [15:0] cycles;
        logic [15:0] exp_cnt;
        logic        exp_flag;
    } vec_t;

    // ctrl, lo, hi, cycles, expected count, expected flag
    localparam vec_t VECS [9] = '{
        '{8'h88, 8'h0A, 8'h00, 16'd5,   16'h000F, 1'b0},  // R2 bypass, internal
        '{8'h88, 8'hFE, 8'hFF, 16'd3,   16'h0001, 1'b1},  // R6 16-bit wrap
        '{8'h88, 8'hFE, 8'h12, 16'd4,   16'h1302, 1'b0},  // R6 carry, no flag
        '{8'hC8, 8'hFE, 8'h12, 16'd4,   16'h1202, 1'b1},  // R5 8-bit wrap
        '{8'h80, 8'h00, 8'h00, 16'd7,   16'h0003, 1'b0},  // R3 1:2
        '{8'h83, 8'h00, 8'h00, 16'd40,  16'h0002, 1'b0},  // R3 1:16
        '{8'h87, 8'h00, 8'h00, 16'd600, 16'h0002, 1'b0},  // R3 1:256
        '{8'hC1, 8'hFD, 8'h00, 16'd12,  16'h0000, 1'b1},  // R3 R5 1:4, 8-bit
        '{8'h08, 8'h05, 8'h00, 16'd10,  16'h0005, 1'b0}   // R9 stopped
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one write strobe at the current falling edge for one clock.
    task automatic do_write(input int sel, input logic [7:0] d);
        wr_data_i   = d;
        wr_ctrl_i   = (sel == 0);
        wr_tmr_lo_i = (sel == 1);
        wr_tmr_hi_i = (sel == 2);
        wr_flag_i   = (sel == 3);
        wr_ie_i     = (sel == 4);
        @(negedge clk);
        {wr_ctrl_i, wr_tmr_lo_i, wr_tmr_hi_i, wr_flag_i, wr_ie_i} = '0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] snap;
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(1);

        // R1: reset state; idle pin, external source selected, nothing counts.
        check("R1 count", cnt_o, 16'h0000);
        check("R1 flag", {15'd0, flag_o}, 16'd0);
        check("R1 irq", {15'd0, irq_o}, 16'd0);
        wait_cyc(10);
        check("R1 idle pin holds", cnt_o, 16'h0000);
        // R1 R11: reset control counts falling pin edges only.
        ext_cnt_i = 1'b1; wait_cyc(5);
        check("R11 rising ignored", cnt_o, 16'h0000);
        ext_cnt_i = 1'b0; wait_cyc(5);
        check("R1 falling counted", cnt_o, 16'h0001);

        // Table walk on the internal clock.
        foreach (VECS[i]) begin
            do_write(0, VECS[i].ctrl & 8'h7F);
            do_write(1, VECS[i].lo);
            do_write(2, VECS[i].hi);
            do_write(3, 8'h00);
            do_write(0, VECS[i].ctrl);
            wait_cyc(int'(VECS[i].cycles));
            check($sformatf("vector %0d count", i), cnt_o, VECS[i].exp_cnt);
            check($sformatf("vector %0d flag", i), {15'd0, flag_o}, {15'd0, VECS[i].exp_flag});
        end

        // R11: rising edges, latency of three clocks, falling ignored.
        do_write(0, 8'h28);
        do_write(1, 8'h00);
        do_write(2, 8'h00);
        do_write(0, 8'hA8);
        ext_cnt_i = 1'b1;
        wait_cyc(2);
        check("R11 before latency", cnt_o, 16'h0000);
        wait_cyc(1);
        check("R11 after three clocks", cnt_o, 16'h0001);
        wait_cyc(3);
        ext_cnt_i = 1'b0;
        wait_cyc(5);
        check("R11 falling ignored", cnt_o, 16'h0001);

        // R4: timer write clears the prescaler (1:4).
        do_write(0, 8'h01);
        do_write(1, 8'h00);
        do_write(2, 8'h00);
        do_write(0, 8'h81);
        wait_cyc(2);
        do_write(1, 8'h00);
        wait_cyc(3);
        check("R4 cleared prescaler", cnt_o, 16'h0000);
        wait_cyc(1);
        check("R4 tick after full block", cnt_o, 16'h0001);

        // R7 R8: interrupt gating and sticky flag.
        do_write(0, 8'h48);
        do_write(3, 8'h00);
        do_write(4, 8'h01);
        do_write(1, 8'hFF);
        do_write(0, 8'hC8);
        wait_cyc(1);
        check("R7 irq with enable", {14'd0, flag_o, irq_o}, 16'h0003);
        do_write(4, 8'h00);
        check("R7 irq masked", {14'd0, flag_o, irq_o}, 16'h0002);
        wait_cyc(5);
        check("R8 flag sticky", {15'd0, flag_o}, 16'd1);
        do_write(3, 8'h00);
        check("R8 flag cleared", {15'd0, flag_o}, 16'd0);
        do_write(1, 8'hFE);
        wait_cyc(1);
        do_write(3, 8'h00);
        check("R8 overflow beats clear", {15'd0, flag_o}, 16'd1);

        // R10: sleep freezes counting.
        do_write(0, 8'h88);
        do_write(1, 8'h40);
        do_write(2, 8'h00);
        sleep_i = 1'b1;
        snap = cnt_o;
        wait_cyc(10);
        check("R10 sleep holds", cnt_o, snap);
        sleep_i = 1'b0;
        wait_cyc(4);
        check("R10 resumes", cnt_o, snap + 16'd4);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule